// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the register front end of one DMA channel. It holds four 32-bit words reached over a simple 32-bit slave port: a control/status word, a transfer address, and two general storage words. The control/status word combines software-writable control bits with bits that only hardware may change: the interrupt-pending flag, the address-loaded flag and a fixed version code. A write to it has side effects. It can request a peripheral reset, it can request a drain, and it can move the peripheral enable.

The block watches an interrupt line from the attached peripheral. It keeps a pending flag and gates that flag with a software enable to drive a registered interrupt output. It also counts the transfer address forward as the peripheral reports finished transfers, and it presents that address to the peripheral.

Three small state machines carry the behaviour:
- The line tracker has the states LINE_LOW and LINE_HIGH. Its transitions are LOW→HIGH on a sampled high level, which is a rise, and HIGH→LOW on a sampled low level, which is a fall.
- The reset pulser has the states PULSE_IDLE and PULSE_FIRE. Its transitions are IDLE→FIRE on a reset request, FIRE→FIRE on another request, and FIRE→IDLE otherwise.
- The enable follower has the states EN_OFF and EN_ON. Its transitions are OFF→ON when a stored enable bit is set and ON→OFF when it is cleared.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control/status word reads 0xA0000000, and the address and both storage words read 0. `irq_out`, `periph_rst` and `periph_en` are low.
- R2: The word is selected by `bus_addr[3:2]`: 0 selects control/status, 1 the address, 2 and 3 the storage words. All other address bits are ignored. `bus_rdata` shows the selected word, and reading changes nothing.
- R3: Control/status bits 31:25 and 2:0 keep their value on a write. The other bits take the written value. Bits 31:28 always read 0xA, because the value 0xA0000000 is ORed into every write.
- R4: A control/status write with bit 7 set stores bit 7. It also drives `periph_rst` high for exactly the cycle after the write, or for longer if further such writes follow.
- R5: If bit 7 is clear, a written bit 6 (drain) is stored as 0. A written value of exactly 0 is stored with bit 6 set, so the word reads 0xA0000040 when the hardware-owned bits are clear.
- R6: `periph_en` equals stored bit 9. It changes in the cycle after a write that changes that bit and never otherwise.
- R7: Writing index 1 stores the address and sets control/status bit 26. That bit then stays set until reset.
- R8: A rise of `periph_irq` sets pending bit 0 and a fall clears it, both at the edge where the new level is sampled. `irq_out` always equals bit 0 AND bit 4 (interrupt enable) of the stored word.
- R9: A control/status write with bit 4 set raises `irq_out` when pending is already set. A write with bit 4 clear lowers it.
- R10: When `xfer_done` is high, the address grows by `xfer_len` at that edge. A bus write to index 1 in the same cycle wins, and no step is taken.
- R11: `xfer_addr` always equals the stored address word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Slave access valid |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | AW | Byte address (only bits 3:2 decode) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Selected word |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| xfer_done | input | 1 | One peripheral transfer finished this cycle |
| xfer_len | input | LW | Byte count of the finished transfer |
| xfer_addr | output | 32 | Memory address for the next transfer |
| irq_out | output | 1 | Gated interrupt |
| periph_rst | output | 1 | Reset pulse to the peripheral |
| periph_en | output | 1 | Enable level to the peripheral |

## Verification
The control/status word is written with all zeros, a lone drain bit, and all ones including the reset bit. Together these separate the zero-to-drain rewrite, the drain self-clear, read-only preservation and the reset pulse. The interrupt line is raised and dropped both with the enable clear and with it set, and the enable is toggled while pending is held. This tells gating at the line edge apart from gating at the software write. Transfers of 4 and 255 bytes, plus a transfer that collides with an address write, show the step width and the priority of the bus write. Writes through an aliased base such as 0x14 and 0xF8 show that only bits 3:2 decode.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam logic [31:0] VER_FIELD = 32'hA000_0000;
    localparam logic [31:0] RO_MASK   = 32'hFE00_0007;
    localparam int B_PEND  = 0;
    localparam int B_IEN   = 4;
    localparam int B_DRAIN = 6;
    localparam int B_RST   = 7;
    localparam int B_EN    = 9;
    localparam int B_LOAD  = 26;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_ADDR = 2'd1,
        REG_AUX0 = 2'd2,
        REG_AUX1 = 2'd3
    } reg_idx_t;

    typedef enum logic { LINE_LOW, LINE_HIGH }   line_st_t;
    typedef enum logic { PULSE_IDLE, PULSE_FIRE } pulse_st_t;
    typedef enum logic { EN_OFF, EN_ON }         en_st_t;
endpackage

// File: rtl/dcr_line_fsm.sv
module dcr_line_fsm
    import dcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    line_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LINE_LOW:  if (line_i)  st_d = LINE_HIGH;
            LINE_HIGH: if (!line_i) st_d = LINE_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LINE_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        rise_o = (st_q == LINE_LOW)  && line_i;
        fall_o = (st_q == LINE_HIGH) && !line_i;
    end

    // R8
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));
endmodule

// File: rtl/dcr_pulse_fsm.sv
module dcr_pulse_fsm
    import dcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    pulse_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PULSE_IDLE: if (fire_i) st_d = PULSE_FIRE;
            PULSE_FIRE: st_d = fire_i ? PULSE_FIRE : PULSE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PULSE_IDLE;
        else        st_q <= st_d;
    end

    always_comb pulse_o = (st_q == PULSE_FIRE);

    // R4
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pulse_o);
    // R4
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !fire_i) |=> !pulse_o);
endmodule

// File: rtl/dcr_en_fsm.sv
module dcr_en_fsm
    import dcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_bit_i,
    output logic en_o
);
    en_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_OFF: if (en_bit_i)  st_d = EN_ON;
            EN_ON:  if (!en_bit_i) st_d = EN_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EN_OFF;
        else        st_q <= st_d;
    end

    always_comb en_o = (st_q == EN_ON);
endmodule

// File: rtl/dcr_ctl_next.sv
module dcr_ctl_next
    import dcr_pkg::*;
(
    input  logic [31:0] cur_i,
    input  logic        wr_ctl_i,
    input  logic [31:0] wdata_i,
    input  logic        wr_addr_i,
    input  logic        rise_i,
    input  logic        fall_i,
    output logic [31:0] nxt_o,
    output logic        rst_req_o
);
    logic [31:0] v;

    always_comb begin
        v         = wdata_i;
        rst_req_o = 1'b0;
        nxt_o     = cur_i;
        if (wr_ctl_i) begin
            if (v[B_RST])          rst_req_o  = 1'b1;
            else if (v[B_DRAIN])   v[B_DRAIN] = 1'b0;
            else if (v == '0)      v[B_DRAIN] = 1'b1;
            nxt_o = (cur_i & RO_MASK) | (v & ~RO_MASK) | VER_FIELD;
        end
        if (wr_addr_i) nxt_o[B_LOAD] = 1'b1;
        if (rise_i)      nxt_o[B_PEND] = 1'b1;
        else if (fall_i) nxt_o[B_PEND] = 1'b0;
    end
endmodule

// File: rtl/dcr_addr_ctr.sv
module dcr_addr_ctr #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [31:0]   wdata_i,
    input  logic          step_i,
    input  logic [LW-1:0] len_i,
    output logic [31:0]   addr_o
);
    localparam int PAD = 32 - LW;

    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (wr_i)   addr_o <= wdata_i;
        else if (step_i) addr_o <= addr_o + {{PAD{1'b0}}, len_i};
    end

    // R10
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i) |=> addr_o == $past(addr_o) + {{PAD{1'b0}}, $past(len_i)});
    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> addr_o == $past(wdata_i));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dcr_pkg::*;
#(
    parameter int AW = 8,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          periph_irq,
    input  logic          xfer_done,
    input  logic [LW-1:0] xfer_len,
    output logic [31:0]   xfer_addr,
    output logic          irq_out,
    output logic          periph_rst,
    output logic          periph_en
);
    localparam int AUX_N = 2;

    reg_idx_t    idx;
    logic        wr;
    logic        wr_ctl, wr_addr;
    logic [AUX_N-1:0] wr_aux;
    logic [31:0] ctl_q, ctl_d;
    logic [31:0] aux_q [AUX_N];
    logic        irq_rise, irq_fall, rst_req;
    logic        unused_addr_bits;

    assign unused_addr_bits = ^{bus_addr[AW-1:4], bus_addr[1:0]};

    always_comb begin
        idx     = reg_idx_t'(bus_addr[3:2]);
        wr      = bus_sel && bus_we;
        wr_ctl  = wr && (idx == REG_CTL);
        wr_addr = wr && (idx == REG_ADDR);
        wr_aux  = {wr && (idx == REG_AUX1), wr && (idx == REG_AUX0)};
    end

    dcr_line_fsm u_line (
        .clk(clk), .rst_n(rst_n), .line_i(periph_irq),
        .rise_o(irq_rise), .fall_o(irq_fall)
    );

    dcr_ctl_next u_next (
        .cur_i(ctl_q), .wr_ctl_i(wr_ctl), .wdata_i(bus_wdata),
        .wr_addr_i(wr_addr), .rise_i(irq_rise), .fall_i(irq_fall),
        .nxt_o(ctl_d), .rst_req_o(rst_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= VER_FIELD;
            irq_out <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            irq_out <= ctl_d[B_PEND] && ctl_d[B_IEN];
        end
    end

    dcr_pulse_fsm u_pulse (
        .clk(clk), .rst_n(rst_n), .fire_i(rst_req), .pulse_o(periph_rst)
    );

    dcr_en_fsm u_en (
        .clk(clk), .rst_n(rst_n), .en_bit_i(ctl_d[B_EN]), .en_o(periph_en)
    );

    dcr_addr_ctr #(.LW(LW)) u_addr (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_addr), .wdata_i(bus_wdata),
        .step_i(xfer_done), .len_i(xfer_len), .addr_o(xfer_addr)
    );

    for (genvar g = 0; g < AUX_N; g++) begin : g_aux
        always_ff @(posedge clk) begin
            if (!rst_n)        aux_q[g] <= '0;
            else if (wr_aux[g]) aux_q[g] <= bus_wdata;
        end
    end

    always_comb begin
        unique case (idx)
            REG_CTL:  bus_rdata = ctl_q;
            REG_ADDR: bus_rdata = xfer_addr;
            REG_AUX0: bus_rdata = aux_q[0];
            REG_AUX1: bus_rdata = aux_q[1];
        endcase
    end

    // R3
    ver_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[31:28] == 4'hA);
    // R3
    ro_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> ctl_q[25] == $past(ctl_q[25]) && ctl_q[2:1] == $past(ctl_q[2:1]));
    // R7
    loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[B_LOAD] |=> ctl_q[B_LOAD]);
    // R7
    loaded_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr |=> ctl_q[B_LOAD]);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (ctl_q[B_PEND] && ctl_q[B_IEN]));
    // R8
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise |=> ctl_q[B_PEND]);
    // R6
    en_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en == ctl_q[B_EN]);
    // R5
    drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[B_RST] && bus_wdata[B_DRAIN]) |=> !ctl_q[B_DRAIN]);
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        periph_irq = 1'b0, xfer_done = 1'b0;
    logic [7:0]  xfer_len = '0;
    logic [31:0] xfer_addr;
    logic        irq_out, periph_rst, periph_en;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // reference model state
    bit [31:0] m_csr, m_addr, m_aux2, m_aux3;
    bit m_prev, m_irq, m_rst, m_en;

    always #2 clk = ~clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_irq(periph_irq), .xfer_done(xfer_done), .xfer_len(xfer_len),
        .xfer_addr(xfer_addr), .irq_out(irq_out), .periph_rst(periph_rst),
        .periph_en(periph_en)
    );

    function automatic bit [31:0] m_word(input bit [1:0] i);
        case (i)
            2'd0: return m_csr;
            2'd1: return m_addr;
            2'd2: return m_aux2;
            default: return m_aux3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_csr = 32'hA000_0000; m_addr = 0; m_aux2 = 0; m_aux3 = 0;
            m_prev = 0; m_irq = 0; m_rst = 0; m_en = 0;
        end else begin
            bit [31:0] c, v;
            bit pend, rq;
            c = m_csr; rq = 0;
            pend = c[0];
            if (periph_irq && !m_prev) pend = 1;
            if (!periph_irq && m_prev) pend = 0;
            if (bus_sel && bus_we) begin
                case (bus_addr[3:2])
                    2'd0: begin
                        v = bus_wdata;
                        if (v[7]) rq = 1;
                        else if (v[6]) v[6] = 0;
                        else if (v == 0) v = 32'h40;
                        c = (c & 32'hFE00_0007) | (v & ~32'hFE00_0007) | 32'hA000_0000;
                    end
                    2'd1: c[26] = 1;
                    2'd2: m_aux2 = bus_wdata;
                    default: m_aux3 = bus_wdata;
                endcase
            end
            if (bus_sel && bus_we && bus_addr[3:2] == 2'd1) m_addr = bus_wdata;
            else if (xfer_done) m_addr = m_addr + 32'(xfer_len);
            c[0] = pend;
            m_csr = c;
            m_irq = c[0] & c[4];
            m_en = c[9];
            m_rst = rq;
            m_prev = periph_irq;
        end
    end

    task automatic chk(input bit [31:0] act, input bit [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(32'(irq_out),    32'(m_irq),  "R8 irq_out");
            chk(32'(periph_rst), 32'(m_rst),  "R4 periph_rst");
            chk(32'(periph_en),  32'(m_en),   "R6 periph_en");
            chk(xfer_addr,       m_addr,      "R11 xfer_addr");
            chk(bus_rdata, m_word(bus_addr[3:2]), "R2 bus_rdata");
        end
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd_chk(input bit [7:0] a, input bit [31:0] exp, input string tag);
        bus_addr = a; #1;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic xfer(input bit [7:0] n);
        @(negedge clk); #1;
        xfer_done = 1; xfer_len = n;
        @(negedge clk); #1;
        xfer_done = 0;
    endtask

    task automatic irq_set(input bit lvl);
        @(negedge clk); #1;
        periph_irq = lvl;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        // R1 reset values
        rd_chk(8'h00, 32'hA000_0000, "R1 csr");
        rd_chk(8'h04, 32'h0, "R1 addr");
        rd_chk(8'h08, 32'h0, "R1 aux0");
        rd_chk(8'h0C, 32'h0, "R1 aux1");
        chk({irq_out, periph_rst, periph_en}, 0, "R1 outputs");

        // R5 zero becomes drain; drain self-clears
        wr(8'h00, 32'h0);
        rd_chk(8'h00, 32'hA000_0040, "R5 zero write");
        wr(8'h00, 32'h40);
        rd_chk(8'h00, 32'hA000_0000, "R5 drain clear");

        // R4 reset pulse, R3 read-only keep, R6 enable rise
        @(negedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk); #1;
        bus_sel = 0; bus_we = 0;
        chk(32'(periph_rst), 1, "R4 pulse high");
        chk(32'(periph_en), 1, "R6 enable rises");
        rd_chk(8'h00, 32'hA1FF_FFF8, "R3 ro bits kept");
        @(negedge clk); #1;
        chk(32'(periph_rst), 0, "R4 pulse one cycle");

        // R8 rise with enable set
        irq_set(1);
        chk(32'(irq_out), 1, "R8 irq raised");
        // R9 write with enable clear lowers, pending kept
        wr(8'h00, 32'h200);
        chk(32'(irq_out), 0, "R9 irq lowered");
        rd_chk(8'h00, 32'hA000_0201, "R9 pending kept");
        chk(32'(periph_en), 1, "R6 enable unchanged");
        wr(8'h00, 32'h210);
        chk(32'(irq_out), 1, "R9 irq re-raised");
        irq_set(0);
        chk(32'(irq_out), 0, "R8 fall lowers");
        rd_chk(8'h00, 32'hA000_0210, "R8 pending cleared");
        // R8 rise with enable clear: pending only
        wr(8'h00, 32'h200);
        irq_set(1);
        chk(32'(irq_out), 0, "R8 gated off");
        rd_chk(8'h00, 32'hA000_0201, "R8 pending set");
        irq_set(0);

        // R7 / R2 aliased address write
        wr(8'h14, 32'h0000_1000);
        rd_chk(8'h04, 32'h0000_1000, "R2 alias decode");
        rd_chk(8'h00, 32'hA400_0200, "R7 loaded set");
        // R10 steps
        xfer(8'd4);
        xfer(8'd4);
        chk(xfer_addr, 32'h0000_1008, "R10 step 4");
        xfer(8'd255);
        chk(xfer_addr, 32'h0000_1107, "R10 step 255");
        // R10 collision: write wins
        @(negedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = 8'h04; bus_wdata = 32'hDEAD_0000;
        xfer_done = 1; xfer_len = 8'd16;
        @(negedge clk); #1;
        bus_sel = 0; bus_we = 0; xfer_done = 0;
        chk(xfer_addr, 32'hDEAD_0000, "R10 write wins");

        // R2 storage words through upper aliases
        wr(8'hF8, 32'h1234_5678);
        wr(8'h1C, 32'h9ABC_DEF0);
        rd_chk(8'h08, 32'h1234_5678, "R2 aux0");
        rd_chk(8'h0C, 32'h9ABC_DEF0, "R2 aux1");
        repeat (3) @(negedge clk);
        rd_chk(8'h08, 32'h1234_5678, "R2 read no effect");

        // R6 enable falls, R7 loaded survives
        wr(8'h00, 32'h0);
        chk(32'(periph_en), 0, "R6 enable falls");
        rd_chk(8'h00, 32'hA400_0040, "R7 loaded sticky");
        repeat (4) @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule